// File: doc/BRIEF.md
# Reversible Gate-Line Scanner with Enable Gating

This block drives the row (gate) lines of an active-matrix display panel. A frame begins when a start pulse is seen on a line-clock step. On every later step the selected row moves by one. The scan runs either from the top row downward or from the bottom row upward, as the direction input requests. The selected row is driven onto a one-hot gate-select bus only while the enable input is high. This lets the timing generator leave a gap between one row being released and the next row being driven. The block also reports the current row as a binary index, a valid flag, and a one-cycle frame-done pulse.

Two border inputs, both active low, select the active-area shape. With both high, the full 768-row window is used. With only the horizontal-border input low, the full 768-row window is also used (the column area narrows elsewhere in the system). With the vertical-border input low, a centred 640-row window is used. In the 640-row shape, a blanking input drives the black border rows through a separate output. The shape and the direction are captured at each start pulse, so a change during a frame cannot disturb the scan in progress.

The line clock is modelled as a single-cycle step strobe in the system clock domain. The set-up and hold margins of the start pulse against the line clock belong to the upstream timing generator.

Top module: `gate_line_scanner`

## Requirements
- R1: At most one bit of `gate_sel` is high in any cycle, and that bit is the row reported on `row_idx`.
- R2: `gate_sel` is all zero whenever `gate_en` is low or no frame is in progress. While a frame is in progress and `gate_en` is high, bit `row_idx` is set.
- R3: The active row window is rows 0 to 767 in shape codes 0 and 1. In shape code 2 it is rows 64 to 703, which is 640 rows centred in the 768.
- R4: A start step with `dir_down`=1 selects the lowest row of the window, and each later step adds one. With `dir_down`=0 the start step selects the highest row, and each later step subtracts one.
- R5: A step taken while the final row of the scan direction is selected returns the block to idle (`row_valid`=0). `frame_done` is then high for exactly the following cycle.
- R6: At each start step the shape is captured on `frame_mode` using these codes: 2 if `vborder_n`=0; otherwise 1 if `hborder_n`=0; otherwise 0. After reset the code is 0.
- R7: `border_drive` equals `blank` AND `gate_en` while the captured shape code is 2, and is 0 for the other shapes.
- R8: Every input except `gate_en` and `blank` is acted on only in cycles where `line_step`=1. A start pulse without a step leaves the row and the valid flag unchanged.
- R9: A change of `dir_down` or of the border inputs during a frame has no effect until the next start step. A start step during a frame restarts the scan at the first row, using the inputs present at that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_step | input | 1 | One-cycle strobe marking a line-clock edge |
| vstart | input | 1 | Frame start pulse, sampled on a step |
| dir_down | input | 1 | 1 = top-down scan, 0 = bottom-up scan |
| gate_en | input | 1 | Gate enable; a row is driven only while it is high |
| hborder_n | input | 1 | Low selects the horizontally bordered shape (code 1) |
| vborder_n | input | 1 | Low selects the 640-row shape (code 2) |
| blank | input | 1 | Black-border drive request in the 640-row shape |
| gate_sel | output | 768 | One-hot gate-line select bus |
| row_idx | output | 10 | Index of the selected row |
| row_valid | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-cycle pulse after the final row is released |
| frame_mode | output | 2 | Captured shape code |
| border_drive | output | 1 | Border rows are being driven black |

## Verification
A wrong row counter shows up at the ports within one step. `row_idx` and the lit bit of `gate_sel` then leave the expected sequence, or they leave the window of the captured shape. A wrong end-of-frame compare either ends the frame early or runs it past the window edge. Either way, `frame_done` rises in the wrong cycle. A direction or shape latch that follows its input during a frame shows up on the next step after the input toggles. The scan moves the wrong way, or `frame_mode` changes.

// File: rtl/gls_pkg.sv
package gls_pkg;
  typedef enum logic [1:0] {
    SHAPE_FULL  = 2'd0,
    SHAPE_HBORD = 2'd1,
    SHAPE_SHORT = 2'd2
  } shape_e;

  // lowest row of the active window for a shape
  function automatic int unsigned window_lo(shape_e s, int unsigned rows, int unsigned short_rows);
    return (s == SHAPE_SHORT) ? (rows - short_rows) / 2 : 0;
  endfunction

  // highest row of the active window for a shape
  function automatic int unsigned window_hi(shape_e s, int unsigned rows, int unsigned short_rows);
    return window_lo(s, rows, short_rows) + ((s == SHAPE_SHORT) ? short_rows : rows) - 1;
  endfunction

  // shape decode: the vertical border has priority over the horizontal one
  function automatic shape_e decode_shape(logic hb_n, logic vb_n);
    if (!vb_n) return SHAPE_SHORT;
    if (!hb_n) return SHAPE_HBORD;
    return SHAPE_FULL;
  endfunction
endpackage

// File: rtl/gls_row_sequencer.sv
module gls_row_sequencer
  import gls_pkg::*;
#(
  parameter int unsigned ROWS       = 768,
  parameter int unsigned SHORT_ROWS = 640,
  localparam int unsigned IDX_W     = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_step,
  input  logic             vstart,
  input  logic             dir_down,
  input  shape_e           shape_in,
  output logic             active,
  output logic [IDX_W-1:0] row,
  output shape_e           shape_q,
  output logic             dir_q,
  output logic             start_evt,
  output logic             end_evt,
  output logic             frame_done
);
  logic [IDX_W-1:0] new_lo, new_hi, cur_lo, cur_hi, first_row, final_row;

  assign new_lo    = IDX_W'(window_lo(shape_in, ROWS, SHORT_ROWS));
  assign new_hi    = IDX_W'(window_hi(shape_in, ROWS, SHORT_ROWS));
  assign cur_lo    = IDX_W'(window_lo(shape_q, ROWS, SHORT_ROWS));
  assign cur_hi    = IDX_W'(window_hi(shape_q, ROWS, SHORT_ROWS));
  assign first_row = dir_down ? new_lo : new_hi;
  assign final_row = dir_q ? cur_hi : cur_lo;

  assign start_evt = line_step & vstart;
  assign end_evt   = line_step & ~vstart & active & (row == final_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      row        <= '0;
      shape_q    <= SHAPE_FULL;
      dir_q      <= 1'b1;
      frame_done <= 1'b0;
    end else begin
      frame_done <= end_evt;
      if (start_evt) begin
        active  <= 1'b1;
        row     <= first_row;
        shape_q <= shape_in;
        dir_q   <= dir_down;
      end else if (end_evt) begin
        active <= 1'b0;
        row    <= '0;
      end else if (line_step && active) begin
        row <= dir_q ? row + IDX_W'(1) : row - IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/gls_gate_decoder.sv
module gls_gate_decoder #(
  parameter int unsigned ROWS   = 768,
  localparam int unsigned IDX_W = $clog2(ROWS)
) (
  input  logic             active,
  input  logic             gate_en,
  input  logic [IDX_W-1:0] row,
  output logic [ROWS-1:0]  gate_sel
);
  for (genvar g = 0; g < ROWS; g++) begin : g_line
    assign gate_sel[g] = active & gate_en & (row == IDX_W'(g));
  end
endmodule

// File: rtl/gate_line_scanner.sv
module gate_line_scanner
  import gls_pkg::*;
#(
  parameter int unsigned ROWS       = 768,
  parameter int unsigned SHORT_ROWS = 640,
  localparam int unsigned IDX_W     = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_step,
  input  logic             vstart,
  input  logic             dir_down,
  input  logic             gate_en,
  input  logic             hborder_n,
  input  logic             vborder_n,
  input  logic             blank,
  output logic [ROWS-1:0]  gate_sel,
  output logic [IDX_W-1:0] row_idx,
  output logic             row_valid,
  output logic             frame_done,
  output logic [1:0]       frame_mode,
  output logic             border_drive
);
  shape_e shape_in, shape_q;
  logic   active, dir_q, start_evt, end_evt;

  assign shape_in = decode_shape(hborder_n, vborder_n);

  gls_row_sequencer #(.ROWS(ROWS), .SHORT_ROWS(SHORT_ROWS)) seq_i (
    .clk(clk), .rst_n(rst_n), .line_step(line_step), .vstart(vstart),
    .dir_down(dir_down), .shape_in(shape_in), .active(active), .row(row_idx),
    .shape_q(shape_q), .dir_q(dir_q), .start_evt(start_evt), .end_evt(end_evt),
    .frame_done(frame_done)
  );

  gls_gate_decoder #(.ROWS(ROWS)) dec_i (
    .active(active), .gate_en(gate_en), .row(row_idx), .gate_sel(gate_sel)
  );

  assign row_valid    = active;
  assign frame_mode   = shape_q;
  assign border_drive = (shape_q == SHAPE_SHORT) & blank & gate_en;
endmodule

// File: rtl/gls_checker.sv
module gls_checker #(
  parameter int unsigned ROWS       = 768,
  parameter int unsigned SHORT_ROWS = 640,
  localparam int unsigned IDX_W     = $clog2(ROWS),
  localparam int unsigned OFFS      = (ROWS - SHORT_ROWS) / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_step,
  input logic             vstart,
  input logic             gate_en,
  input logic [ROWS-1:0]  gate_sel,
  input logic [IDX_W-1:0] row_idx,
  input logic             row_valid,
  input logic             frame_done,
  input logic [1:0]       frame_mode,
  input logic             start_evt,
  input logic             end_evt,
  input logic             dir_q
);
  a_r1_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_sel));

  a_r2_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> gate_sel == '0);

  a_r3_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && frame_mode == 2'd2) |-> (row_idx >= IDX_W'(OFFS) && row_idx <= IDX_W'(OFFS + SHORT_ROWS - 1)));

  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_step && row_valid && !vstart && !end_evt) |=>
      row_idx == ($past(dir_q) ? $past(row_idx) + IDX_W'(1) : $past(row_idx) - IDX_W'(1)));

  a_r5_done_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (frame_done && !row_valid));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r8_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    !line_step |=> ($stable(row_idx) && $stable(row_valid)));

  a_r9_start_enters_frame: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> row_valid && !frame_done);
endmodule

bind gate_line_scanner gls_checker #(.ROWS(ROWS), .SHORT_ROWS(SHORT_ROWS)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_step(line_step), .vstart(vstart),
  .gate_en(gate_en), .gate_sel(gate_sel), .row_idx(row_idx), .row_valid(row_valid),
  .frame_done(frame_done), .frame_mode(frame_mode), .start_evt(start_evt),
  .end_evt(end_evt), .dir_q(dir_q)
);

// File: tb/gate_line_scanner_tb.sv
module gate_line_scanner_tb_top;
  localparam int ROWS = 768;
  localparam int IW   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_step = 0, vstart = 0, dir_down = 1, gate_en = 0;
  logic hborder_n = 1, vborder_n = 1, blank = 0;
  logic [ROWS-1:0] gate_sel;
  logic [IW-1:0]   row_idx;
  logic            row_valid, frame_done, border_drive;
  logic [1:0]      frame_mode;

  int checks = 0, failures = 0;
  bit finished = 0;
  string tag = "R6";

  // reference model state
  int m_act = 0, m_row = 0, m_shape = 0, m_dir = 1, m_done = 0;

  always #4 clk = ~clk;

  gate_line_scanner dut_i (
    .clk(clk), .rst_n(rst_n), .line_step(line_step), .vstart(vstart),
    .dir_down(dir_down), .gate_en(gate_en), .hborder_n(hborder_n),
    .vborder_n(vborder_n), .blank(blank), .gate_sel(gate_sel), .row_idx(row_idx),
    .row_valid(row_valid), .frame_done(frame_done), .frame_mode(frame_mode),
    .border_drive(border_drive)
  );

  function automatic int lo_of(int s);
    return (s == 2) ? 64 : 0;
  endfunction
  function automatic int hi_of(int s);
    return (s == 2) ? 703 : 767;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int ones;
    int exp_bit;
    ones = $countones(gate_sel);
    exp_bit = (m_act != 0 && gate_en) ? 1 : 0;
    check(row_valid == (m_act != 0), "R5 row_valid", int'(row_valid), m_act);
    if (m_act != 0)
      check(int'(row_idx) == m_row, "R3 R4 row_idx", int'(row_idx), m_row);
    check(ones == exp_bit, "R1 R2 gate_sel ones", ones, exp_bit);
    if (exp_bit == 1)
      check(gate_sel[m_row] == 1'b1, "R1 gate_sel bit at row", m_row, m_row);
    check(int'(frame_done) == m_done, "R5 frame_done", int'(frame_done), m_done);
    check(int'(frame_mode) == m_shape, "R6 frame_mode", int'(frame_mode), m_shape);
    check(int'(border_drive) == ((m_shape == 2 && blank && gate_en) ? 1 : 0),
          "R7 border_drive", int'(border_drive), (m_shape == 2 && blank && gate_en) ? 1 : 0);
  endtask

  // one cycle: check current outputs, apply new inputs, advance the model
  task automatic cyc(bit st, bit vs, bit dn, bit en, bit hb, bit vb, bit bl);
    @(negedge clk);
    compare();
    line_step = st; vstart = vs; dir_down = dn; gate_en = en;
    hborder_n = hb; vborder_n = vb; blank = bl;
    m_done = 0;
    if (st) begin
      if (vs) begin
        m_act = 1;
        m_shape = !vb ? 2 : (!hb ? 1 : 0);
        m_dir = dn;
        m_row = dn ? lo_of(m_shape) : hi_of(m_shape);
      end else if (m_act != 0) begin
        if (m_row == (m_dir != 0 ? hi_of(m_shape) : lo_of(m_shape))) begin
          m_act = 0; m_row = 0; m_done = 1;
        end else begin
          m_row = m_row + (m_dir != 0 ? 1 : -1);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6: reset state, idle
    tag = "R6";
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 1, 1, 1);

    // full-window top-down frame, enable chopped
    tag = "R4";
    cyc(1, 1, 1, 1, 1, 1, 0);
    for (int i = 0; i < 770; i++) cyc(1, 0, 1, (i % 3) != 0, 1, 1, i[0]);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 1, 1, 0);

    // 640-row bottom-up frame, steps every other cycle, blank toggling;
    // start pulses without step and direction/border toggles are ignored
    tag = "R8";
    cyc(1, 1, 0, 1, 1, 0, 1);
    for (int i = 0; i < 1300; i++)
      cyc(i[0], ~i[0] & (i % 7 == 0), i[3], (i % 5) != 0, i[4], i[5], i[1]);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 1, 1, 1);

    // horizontally bordered shape, restart mid-frame in the other direction
    tag = "R9";
    cyc(1, 1, 1, 1, 0, 1, 1);
    for (int i = 0; i < 100; i++) cyc(1, 0, 0, 1, 1, 0, 1);
    cyc(1, 1, 0, 1, 0, 1, 0);
    for (int i = 0; i < 771; i++) cyc(1, 0, 1, (i % 4) != 1, 1, 1, 1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 1, 1, 0);

    // 640-row top-down frame, blank with enable low then high
    tag = "R7";
    cyc(1, 1, 1, 0, 1, 0, 1);
    for (int i = 0; i < 645; i++) cyc(1, 0, 1, i[2], 1, 1, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, i[0], 1, 1, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", tag, 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule